// File: doc/BRIEF.md
# Cascaded Interval Timer with Expiry-Synchronised Output Group

This block chains two reloadable down-counters. The first stage (the base counter) counts down by one per clock and sets the basic time step. The second stage (the cascade counter) moves only when the base counter expires, so its period is a whole number of base periods. When the cascade counter expires, a staged bit pattern is copied onto a group of real-time output pins in the same clock edge. Software can prepare the next pattern at any time without disturbing the pins.

Software loads the two reload values and the staged pattern through write strobes. Both counters start together from one start pulse and freeze on a stop pulse. Each stage has an expiry interrupt pulse. When the timer does not own the output group (output enable low), software can set the pin levels directly, for example to give them initial values before a run.

Top module: `cascade_timer`

## Requirements
- R1: A synchronous reset (`rst` high) clears both counts, both interrupt outputs, the staged pattern, the reload values and `rtOut` to zero.
- R2: While running, `masterCount` drops by one each clock. On the clock after it reads zero, it shows the base reload value again. A base reload value M gives a period of M+1 clocks, and M=0 expires on every clock.
- R3: `masterIrq` is high for exactly the clock cycle that follows each cycle in which the running base count is zero.
- R4: `slaveCount` changes only on base expiries. On a base expiry it drops by one, or, if it was zero, it shows the cascade reload value again.
- R5: `slaveIrq` is high for exactly the cycle that follows a base expiry during which the cascade count was zero. It is therefore never high without `masterIrq`.
- R6: `rtOut` takes the staged pattern on the same edge that raises `slaveIrq`, and only if `outEnable` was 1 in the expiry cycle. Writing the staged pattern (`wrStage`) never changes `rtOut` by itself.
- R7: A start pulse (`startPulse` for one cycle, with `stopPulse` low) makes the timer run. On the next edge it loads `masterCount` and `slaveCount` from their active reload values. A start pulse while running restarts both counts the same way.
- R8: A stop pulse halts the timer. Both counts and `rtOut` keep their values, and no interrupt is raised on the stop edge. When start and stop arrive in the same cycle, stop wins.
- R9: While running, a reload write is held pending and becomes the active reload value at the next base expiry edge. The reload done on that same edge still uses the old value. While stopped, a reload write becomes active at once.
- R10: A direct pin write (`pinWrite`) sets `rtOut` to `pinData` on the next edge when `outEnable` is 0. It is ignored when `outEnable` is 1.
- R11: The counter width (`CNT_W`, default 16) and the output group width (`OUT_W`, default 6) are parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrMaster | input | 1 | Write strobe for the base reload value |
| wrSlave | input | 1 | Write strobe for the cascade reload value |
| wrData | input | CNT_W | Reload value for either write |
| wrStage | input | 1 | Write strobe for the staged output pattern |
| stageData | input | OUT_W | Staged output pattern |
| startPulse | input | 1 | Start/restart trigger, one cycle |
| stopPulse | input | 1 | Stop trigger, one cycle |
| outEnable | input | 1 | 1: expiries drive `rtOut`; 0: direct pin writes drive it |
| pinWrite | input | 1 | Direct pin write strobe |
| pinData | input | OUT_W | Direct pin level value |
| masterCount | output | CNT_W | Current base count |
| slaveCount | output | CNT_W | Current cascade count |
| masterIrq | output | 1 | Base expiry pulse |
| slaveIrq | output | 1 | Cascade expiry pulse |
| rtOut | output | OUT_W | Real-time output group |

## Verification
Each piece of internal state shows up at the ports within one clock. A wrong base count is visible in `masterCount` at once and moves `masterIrq` by the same error. A wrong cascade count or a missed base tick shifts `slaveIrq` and the next `rtOut` update by whole base periods. A pending reload that is committed at the wrong time shows up as a wrong period length right after the next expiry. A bad staged pattern, or a bad commit condition, shows as a wrong `rtOut` value on the first cascade expiry after it, or as an `rtOut` change on a cycle with no expiry. The bench therefore compares every output against its reference on every clock.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef struct packed {
    logic loadCnt;     // restart both counters from active reloads
    logic stepBase;    // base counter advances this cycle
    logic expBase;     // base counter expires this cycle
    logic expCascade;  // cascade counter expires this cycle
    logic commitPins;  // copy staged pattern to pins
    logic directPins;  // software sets pins directly
    logic idle;        // timer halted: reload writes apply at once
  } ctStrobes_t;
endpackage

// File: rtl/ct_reload_lane.sv
module ct_reload_lane #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             advance,
  input  logic             commit,
  input  logic             idle,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             atZero
);
  logic [CNT_W-1:0] activeVal;
  logic [CNT_W-1:0] pendingVal;

  assign atZero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      activeVal  <= '0;
      pendingVal <= '0;
    end else begin
      if (load) begin
        count <= activeVal;
      end else if (advance) begin
        count <= atZero ? activeVal : count - 1'b1;
      end
      if (commit) begin
        activeVal <= pendingVal;
      end
      if (wrEn) begin
        pendingVal <= wrData;
        if (idle) begin
          activeVal <= wrData;
        end
      end
    end
  end
endmodule

// File: rtl/ct_ctrl.sv
module ct_ctrl
  import ct_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startPulse,
  input  logic       stopPulse,
  input  logic       outEnable,
  input  logic       pinWrite,
  input  logic       baseZero,
  input  logic       cascadeZero,
  output ctStrobes_t stb,
  output logic       masterIrq,
  output logic       slaveIrq
);
  logic running;
  logic doLoad;
  logic doRun;

  assign doLoad = startPulse & ~stopPulse;
  assign doRun  = running & ~stopPulse & ~startPulse;

  always_comb begin
    stb            = '0;
    stb.loadCnt    = doLoad;
    stb.stepBase   = doRun;
    stb.expBase    = doRun & baseZero;
    stb.expCascade = doRun & baseZero & cascadeZero;
    stb.commitPins = doRun & baseZero & cascadeZero & outEnable;
    stb.directPins = pinWrite & ~outEnable;
    stb.idle       = ~running;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      masterIrq <= 1'b0;
      slaveIrq  <= 1'b0;
    end else begin
      if (stopPulse)       running <= 1'b0;
      else if (startPulse) running <= 1'b1;
      masterIrq <= stb.expBase;
      slaveIrq  <= stb.expCascade;
    end
  end
endmodule

// File: rtl/ct_datapath.sv
module ct_datapath
  import ct_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  ctStrobes_t       stb,
  input  logic             wrMaster,
  input  logic             wrSlave,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrStage,
  input  logic [OUT_W-1:0] stageData,
  input  logic [OUT_W-1:0] pinData,
  output logic [CNT_W-1:0] masterCount,
  output logic [CNT_W-1:0] slaveCount,
  output logic             baseZero,
  output logic             cascadeZero,
  output logic [OUT_W-1:0] rtOut
);
  localparam int LANES = 2;

  logic [LANES-1:0]            laneAdvance;
  logic [LANES-1:0]            laneWr;
  logic [LANES-1:0]            laneZero;
  logic [LANES-1:0][CNT_W-1:0] laneCount;
  logic [OUT_W-1:0]            stageReg;

  assign laneAdvance = {stb.expBase, stb.stepBase};
  assign laneWr      = {wrSlave, wrMaster};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ct_reload_lane #(.CNT_W(CNT_W)) lane_i (
      .clk    (clk),
      .rst    (rst),
      .load   (stb.loadCnt),
      .advance(laneAdvance[g]),
      .commit (stb.expBase),
      .idle   (stb.idle),
      .wrEn   (laneWr[g]),
      .wrData (wrData),
      .count  (laneCount[g]),
      .atZero (laneZero[g])
    );
  end

  assign masterCount = laneCount[0];
  assign slaveCount  = laneCount[1];
  assign baseZero    = laneZero[0];
  assign cascadeZero = laneZero[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      stageReg <= '0;
      rtOut    <= '0;
    end else begin
      if (wrStage) stageReg <= stageData;
      if (stb.commitPins)      rtOut <= stageReg;
      else if (stb.directPins) rtOut <= pinData;
    end
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer #(
  parameter int CNT_W = 16,
  parameter int OUT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrMaster,
  input  logic             wrSlave,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrStage,
  input  logic [OUT_W-1:0] stageData,
  input  logic             startPulse,
  input  logic             stopPulse,
  input  logic             outEnable,
  input  logic             pinWrite,
  input  logic [OUT_W-1:0] pinData,
  output logic [CNT_W-1:0] masterCount,
  output logic [CNT_W-1:0] slaveCount,
  output logic             masterIrq,
  output logic             slaveIrq,
  output logic [OUT_W-1:0] rtOut
);
  ct_pkg::ctStrobes_t stb;
  logic baseZero;
  logic cascadeZero;

  ct_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .outEnable  (outEnable),
    .pinWrite   (pinWrite),
    .baseZero   (baseZero),
    .cascadeZero(cascadeZero),
    .stb        (stb),
    .masterIrq  (masterIrq),
    .slaveIrq   (slaveIrq)
  );

  ct_datapath #(.CNT_W(CNT_W), .OUT_W(OUT_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .wrMaster   (wrMaster),
    .wrSlave    (wrSlave),
    .wrData     (wrData),
    .wrStage    (wrStage),
    .stageData  (stageData),
    .pinData    (pinData),
    .masterCount(masterCount),
    .slaveCount (slaveCount),
    .baseZero   (baseZero),
    .cascadeZero(cascadeZero),
    .rtOut      (rtOut)
  );
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int CNT_W = 16,
  parameter int OUT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             startPulse,
  input logic             stopPulse,
  input logic             outEnable,
  input logic             pinWrite,
  input logic [CNT_W-1:0] masterCount,
  input logic [CNT_W-1:0] slaveCount,
  input logic             masterIrq,
  input logic             slaveIrq,
  input logic [OUT_W-1:0] rtOut
);
  AST_MIRQ_AFTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    masterIrq |-> ($past(masterCount) == '0)); // R3

  AST_SIRQ_WITH_MIRQ: assert property (@(posedge clk) disable iff (rst)
    slaveIrq |-> masterIrq); // R5

  AST_CASCADE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(slaveCount)) |-> (masterIrq || $past(startPulse && !stopPulse))); // R4

  AST_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !slaveIrq && !$past(pinWrite && !outEnable)) |-> $stable(rtOut)); // R6

  AST_STOP_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stopPulse)) |-> (!masterIrq && !slaveIrq)); // R8

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stopPulse)) |-> ($stable(masterCount) && $stable(slaveCount))); // R8
endmodule

bind cascade_timer ct_checker #(.CNT_W(CNT_W), .OUT_W(OUT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .startPulse (startPulse),
  .stopPulse  (stopPulse),
  .outEnable  (outEnable),
  .pinWrite   (pinWrite),
  .masterCount(masterCount),
  .slaveCount (slaveCount),
  .masterIrq  (masterIrq),
  .slaveIrq   (slaveIrq),
  .rtOut      (rtOut)
);

// File: tb/cascade_timer_tb_top.sv
module cascade_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int OW = 6;

  logic clk = 1'b0;
  logic rst;
  logic wrMaster, wrSlave, wrStage, startPulse, stopPulse, outEnable, pinWrite;
  logic [CW-1:0] wrData;
  logic [OW-1:0] stageData, pinData;
  logic [CW-1:0] masterCount, slaveCount;
  logic masterIrq, slaveIrq;
  logic [OW-1:0] rtOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_timer dut_i (
    .clk(clk), .rst(rst), .wrMaster(wrMaster), .wrSlave(wrSlave), .wrData(wrData),
    .wrStage(wrStage), .stageData(stageData), .startPulse(startPulse),
    .stopPulse(stopPulse), .outEnable(outEnable), .pinWrite(pinWrite),
    .pinData(pinData), .masterCount(masterCount), .slaveCount(slaveCount),
    .masterIrq(masterIrq), .slaveIrq(slaveIrq), .rtOut(rtOut)
  );

  int nChecks = 0;
  int nFail = 0;
  bit cmpOn = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference state
  int mRun, mCnt, sCnt, actM, actS, pendM, pendS, stage, pins, mIrq, sIrq;

  task automatic chk(string nm, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", phase, nm, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mRun = 0; mCnt = 0; sCnt = 0; actM = 0; actS = 0; pendM = 0; pendS = 0;
      stage = 0; pins = 0; mIrq = 0; sIrq = 0;
    end else begin
      int oRun, oM, oS, oActM, oActS, oPendM, oPendS, oStage;
      oRun = mRun; oM = mCnt; oS = sCnt; oActM = actM; oActS = actS;
      oPendM = pendM; oPendS = pendS; oStage = stage;
      mIrq = 0; sIrq = 0;
      if (stopPulse) mRun = 0;
      else if (startPulse) begin
        mRun = 1; mCnt = oActM; sCnt = oActS;
      end else if (oRun != 0) begin
        if (oM == 0) begin
          mCnt = oActM; mIrq = 1; actM = oPendM; actS = oPendS;
          if (oS == 0) begin
            sCnt = oActS; sIrq = 1;
            if (outEnable) pins = oStage;
          end else sCnt = oS - 1;
        end else mCnt = oM - 1;
      end
      if (wrMaster) begin pendM = int'(wrData); if (oRun == 0) actM = int'(wrData); end
      if (wrSlave)  begin pendS = int'(wrData); if (oRun == 0) actS = int'(wrData); end
      if (wrStage) stage = int'(stageData);
      if (pinWrite && !outEnable) pins = int'(pinData);
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      chk("masterCount R2", int'(masterCount), mCnt);
      chk("slaveCount R4", int'(slaveCount), sCnt);
      chk("masterIrq R3", int'(masterIrq), mIrq);
      chk("slaveIrq R5", int'(slaveIrq), sIrq);
      chk("rtOut R6", int'(rtOut), pins);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearStrobes();
    wrMaster = 0; wrSlave = 0; wrStage = 0; startPulse = 0; stopPulse = 0; pinWrite = 0;
  endtask

  task automatic writeReload(bit toSlave, int val);
    wrData = CW'(val);
    if (toSlave) wrSlave = 1; else wrMaster = 1;
    tick(); clearStrobes();
  endtask

  task automatic writeStage(int val);
    stageData = OW'(val); wrStage = 1; tick(); clearStrobes();
  endtask

  task automatic pulseStart();
    startPulse = 1; tick(); clearStrobes();
  endtask

  task automatic pulseStop();
    stopPulse = 1; tick(); clearStrobes();
  endtask

  task automatic finish();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    rst = 1; clearStrobes(); outEnable = 0; wrData = '0; stageData = '0; pinData = '0;
    tick(3);
    rst = 0;
    // R1: reset state visible at the ports
    chk("reset masterCount R1", int'(masterCount), 0);
    chk("reset slaveCount R1", int'(slaveCount), 0);
    chk("reset irqs R1", int'(masterIrq) + int'(slaveIrq), 0);
    chk("reset rtOut R1", int'(rtOut), 0);
    cmpOn = 1;

    phase = "R9"; writeReload(0, 3); writeReload(1, 2);
    writeStage(6'h15); outEnable = 1;
    phase = "R7"; pulseStart();
    chk("start load masterCount R7", int'(masterCount), 3);
    chk("start load slaveCount R7", int'(slaveCount), 2);
    phase = "R2"; tick(40);
    phase = "R6"; writeStage(6'h2A); tick(30);
    phase = "R9"; writeReload(0, 1); writeReload(1, 1); tick(30);
    phase = "R8"; pulseStop(); tick(8);
    startPulse = 1; stopPulse = 1; tick(); clearStrobes(); tick(5);
    phase = "R10"; outEnable = 0; pinData = 6'h33; pinWrite = 1; tick(); clearStrobes(); tick();
    chk("direct pins R10", int'(rtOut), 6'h33);
    outEnable = 1; pinData = 6'h0C; pinWrite = 1; tick(); clearStrobes(); tick();
    chk("direct write ignored R10", int'(rtOut), 6'h33);
    outEnable = 0;
    phase = "R4"; writeReload(0, 0); writeReload(1, 2); writeStage(6'h3F);
    pulseStart(); tick(20);
    phase = "R5"; outEnable = 1; tick(12);
    phase = "R7"; tick(1); pulseStart(); tick(10);
    phase = "R3"; writeReload(0, 4); tick(30);
    phase = "R11";
    chk("rtOut width R11", $bits(rtOut), 6);
    chk("count width R11", $bits(masterCount), 16);
    finish();
  end
endmodule